// File: doc/BRIEF.md
# Video field and line capture controller

This block sits between a processor that writes 12-bit luminance samples over a parallel bus and a downstream image processor that reads tagged words from a host-port style output. It watches three separated sync signals: composite sync, field sync and the odd/even field indicator. From these it works out the parity of the current field and the number of the line being sampled. It then decides whether that field belongs to the capture that software requested.

A capture is requested with a one-cycle start command and a mode. The modes are the odd field only, the even field only, or a complete interlaced frame. A frame always opens with an odd field and closes after the even field that follows it. Writes that fall inside the captured field, and on or after a programmable first active line, are forwarded. Each forwarded word carries the field parity, the line number, a start-of-line flag and the sample. A single pulse marks the end of the capture. The block then stays idle until the next start command.

The output is one register stage with a valid/ready handshake. While the receiver keeps ready high, the stage takes one write per clock. A write that arrives while the stage is stalled is dropped, and a sticky flag records the loss.

Top module: `vid_capture_ctrl`

## Requirements
- R1: After reset, out_valid, overflow and frame_done are all 0.
- R2: The field parity is the synchronised odd_even level taken at each falling edge of vsync_n (1 = odd field). It is carried in bit 23 of out_data.
- R3: Each falling edge of vsync_n clears the line counter to 0. Each falling edge of csync_n then adds 1 to it. The counter value is carried in out_data[22:13].
- R4: A write made while the line counter is below first_line is never forwarded.
- R5: With mode 0 (odd only) at start, the first odd field whose sync edge follows the start is captured, and no other field is.
- R6: With mode 1 (even only) at start, the first even field whose sync edge follows the start is captured, and no other field is.
- R7: With mode 2 or 3 (full frame) at start, even fields are skipped until an odd field begins. That odd field and the even field after it are captured.
- R8: frame_done is a one-cycle pulse raised at the field sync edge that ends the selected capture. After it, no write is forwarded until a new start.
- R9: Bit 12 of out_data is 1 on the first forwarded word after each sync edge, and 0 on every other word. Bits 11:0 of out_data hold the written sample.
- R10: A word is held, with out_valid high and out_data unchanged, while out_ready is low. With out_ready high, a write on every clock cycle is forwarded with none lost.
- R11: A write that would be forwarded, arriving while out_valid is high and out_ready is low, is dropped and sets overflow. overflow stays set until a start command clears it.
- R12: The mode is latched when start is taken from idle. Changing the mode input afterwards has no effect on the capture in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_n | input | 1 | Field sync, active low, asynchronous |
| csync_n | input | 1 | Composite (line) sync, active low, asynchronous |
| odd_even | input | 1 | Field indicator, 1 = odd field, asynchronous |
| mode | input | 2 | Capture mode: 0 odd, 1 even, 2/3 full frame |
| first_line | input | 10 | First line number that is forwarded |
| start | input | 1 | One-cycle start command; arms a capture and clears overflow |
| wr_en | input | 1 | Sample write strobe from the processor bus |
| wr_data | input | 12 | Sample written |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Receiver ready |
| out_data | output | 24 | {parity, line[9:0], start-of-line, sample[11:0]} |
| overflow | output | 1 | Sticky lost-sample flag |
| frame_done | output | 1 | One-cycle pulse when the capture completes |

## Verification
The bench builds the block with its default parameters: 12-bit samples, a 10-bit line number and two synchroniser stages. That fixes the output word at 24 bits and the field positions the scoreboard packs. Since first_line is a port, fields of only a few lines are enough to reach the blanking boundary, every capture mode, the start-of-line tagging and the end-of-capture pulse in a short run. Each line is written with back-to-back samples. One stalled line exercises the hold, the drop and the sticky overflow flag.

// File: rtl/vcap_pkg.sv
package vcap_pkg;

  // Capture selection latched at start
  typedef enum logic [1:0] {
    CAP_ODD  = 2'd0,
    CAP_EVEN = 2'd1,
    CAP_FULL = 2'd2,
    CAP_FULL_ALT = 2'd3
  } cap_mode_e;

  // Field tracker state
  typedef enum logic [1:0] {
    TRK_IDLE   = 2'd0,
    TRK_ARMED  = 2'd1,
    TRK_FIRST  = 2'd2,
    TRK_SECOND = 2'd3
  } trk_state_e;

endpackage

// File: rtl/vcap_sync.sv
// Multi-stage synchroniser for a group of asynchronous levels, with
// falling-edge detection on the low N_EDGE bits.
module vcap_sync #(
  parameter int N      = 3,
  parameter int N_EDGE = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      din,
  output logic [N-1:0]      lvl,
  output logic [N_EDGE-1:0] fall
);

  logic [N-1:0]      stg_q [STAGES];
  logic [N_EDGE-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '1;
    else        stg_q[0] <= din;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '1;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign lvl = stg_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= lvl[N_EDGE-1:0];
  end

  for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
    assign fall[e] = prev_q[e] & ~lvl[e];
  end

endmodule

// File: rtl/vcap_field_track.sv
// Field parity, line counter and capture sequencing.
module vcap_field_track
  import vcap_pkg::*;
#(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vs_fall,
  input  logic              cs_fall,
  input  logic              odd_lvl,
  input  logic              start,
  input  logic [1:0]        mode_in,
  output logic              capture,
  output logic              parity,
  output logic [LINE_W-1:0] line_cnt,
  output logic              frame_done
);

  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  trk_state_e        state_q, state_d;
  cap_mode_e         mode_q, mode_d;
  logic              par_q, par_d;
  logic [LINE_W-1:0] line_q, line_d;
  logic              done_q, done_d;
  logic              full_sel;

  assign full_sel = (mode_q == CAP_FULL) || (mode_q == CAP_FULL_ALT);

  // Line counter and parity
  always_comb begin
    line_d = line_q;
    par_d  = par_q;
    if (vs_fall) begin
      line_d = '0;
      par_d  = odd_lvl;
    end else if (cs_fall && (line_q != LINE_MAX)) begin
      line_d = line_q + 1'b1;
    end
  end

  // Capture sequencing
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    done_d  = 1'b0;
    if (start && (state_q == TRK_IDLE)) begin
      state_d = TRK_ARMED;
      mode_d  = cap_mode_e'(mode_in);
    end else if (vs_fall) begin
      unique case (state_q)
        TRK_ARMED: begin
          if (mode_q == CAP_EVEN) begin
            if (!odd_lvl) state_d = TRK_FIRST;
          end else if (odd_lvl) begin
            state_d = TRK_FIRST;
          end
        end
        TRK_FIRST: begin
          if (full_sel) begin
            if (!odd_lvl) state_d = TRK_SECOND;
          end else begin
            state_d = TRK_IDLE;
            done_d  = 1'b1;
          end
        end
        TRK_SECOND: begin
          state_d = TRK_IDLE;
          done_d  = 1'b1;
        end
        default: state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TRK_IDLE;
      mode_q  <= CAP_ODD;
      par_q   <= 1'b0;
      line_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      par_q   <= par_d;
      line_q  <= line_d;
      done_q  <= done_d;
    end
  end

  assign capture    = (state_q == TRK_FIRST) || (state_q == TRK_SECOND);
  assign parity     = par_q;
  assign line_cnt   = line_q;
  assign frame_done = done_q;

endmodule

// File: rtl/vcap_out_stage.sv
// Single output register with valid/ready, start-of-line tagging and
// sticky overflow.
module vcap_out_stage #(
  parameter int DATA_W = 12,
  parameter int LINE_W = 10,
  localparam int OUT_W = DATA_W + LINE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              parity,
  input  logic [LINE_W-1:0] line_cnt,
  input  logic              line_pulse,
  input  logic              start,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_data,
  output logic              overflow
);

  logic             valid_q, valid_d;
  logic [OUT_W-1:0] data_q, data_d;
  logic             ovf_q, ovf_d;
  logic             sol_q, sol_d;
  logic             load;

  assign load = accept && (!valid_q || out_ready);

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (load) begin
      valid_d = 1'b1;
      data_d  = {parity, line_cnt, sol_q, wr_data};
    end else if (out_ready) begin
      valid_d = 1'b0;
    end

    ovf_d = ovf_q;
    if (accept && valid_q && !out_ready) ovf_d = 1'b1;
    else if (start)                      ovf_d = 1'b0;

    sol_d = sol_q;
    if (line_pulse) sol_d = 1'b1;
    else if (load)  sol_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ovf_q   <= 1'b0;
      sol_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
      ovf_q   <= ovf_d;
      sol_q   <= sol_d;
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign overflow  = ovf_q;

endmodule

// File: rtl/vid_capture_ctrl.sv
module vid_capture_ctrl #(
  parameter int DATA_W      = 12,
  parameter int LINE_W      = 10,
  parameter int SYNC_STAGES = 2,
  localparam int OUT_W      = DATA_W + LINE_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_n,
  input  logic              csync_n,
  input  logic              odd_even,
  input  logic [1:0]        mode,
  input  logic [LINE_W-1:0] first_line,
  input  logic              start,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OUT_W-1:0]  out_data,
  output logic              overflow,
  output logic              frame_done
);

  logic [2:0]        sync_lvl;
  logic [1:0]        sync_fall;
  logic              capture;
  logic              parity;
  logic [LINE_W-1:0] line_cnt;
  logic              accept;

  // bit 0: field sync, bit 1: line sync, bit 2: parity level
  vcap_sync #(
    .N      (3),
    .N_EDGE (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({odd_even, csync_n, vsync_n}),
    .lvl   (sync_lvl),
    .fall  (sync_fall)
  );

  vcap_field_track #(
    .LINE_W (LINE_W)
  ) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .vs_fall    (sync_fall[0]),
    .cs_fall    (sync_fall[1]),
    .odd_lvl    (sync_lvl[2]),
    .start      (start),
    .mode_in    (mode),
    .capture    (capture),
    .parity     (parity),
    .line_cnt   (line_cnt),
    .frame_done (frame_done)
  );

  assign accept = wr_en && capture && (line_cnt >= first_line);

  vcap_out_stage #(
    .DATA_W (DATA_W),
    .LINE_W (LINE_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .wr_data    (wr_data),
    .parity     (parity),
    .line_cnt   (line_cnt),
    .line_pulse (sync_fall[0] | sync_fall[1]),
    .start      (start),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .overflow   (overflow)
  );

endmodule

// File: rtl/vcap_checker.sv
module vcap_checker #(
  parameter int DATA_W = 12,
  parameter int LINE_W = 10,
  localparam int OUT_W = DATA_W + LINE_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [LINE_W-1:0] first_line,
  input logic              out_valid,
  input logic              out_ready,
  input logic [OUT_W-1:0]  out_data,
  input logic              overflow,
  input logic              frame_done
);

  // R8: the completion pulse lasts one cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R10: a stalled word stays put
  p_hold_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R11: overflow only leaves the set state through start
  p_ovf_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !start) |=> overflow);

  // R4: a freshly presented word is never from a blanking line
  p_no_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (out_data[DATA_W+1 +: LINE_W] >= first_line));

endmodule

bind vid_capture_ctrl vcap_checker #(
  .DATA_W (DATA_W),
  .LINE_W (LINE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .first_line (first_line),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .overflow   (overflow),
  .frame_done (frame_done)
);

// File: tb/tb_vid_capture_ctrl.sv
`timescale 1ns/1ps
module tb_vid_capture_ctrl;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        vsync_n, csync_n, odd_even;
  logic [1:0]  mode;
  logic [9:0]  first_line;
  logic        start;
  logic        wr_en;
  logic [11:0] wr_data;
  logic        out_valid, out_ready;
  logic [23:0] out_data;
  logic        overflow, frame_done;

  int n_chk = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int seq = 1;
  bit finished = 0;
  logic [23:0] exp_q[$];

  vid_capture_ctrl dut (
    .clk(clk), .rst_n(rst_n), .vsync_n(vsync_n), .csync_n(csync_n),
    .odd_even(odd_even), .mode(mode), .first_line(first_line),
    .start(start), .wr_en(wr_en), .wr_data(wr_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .overflow(overflow), .frame_done(frame_done)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: a handshake seen after the negedge completes at the next posedge
  always @(negedge clk) begin
    #1;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check("R4 R5 R6 R7 R8 unexpected word", {8'h0, out_data}, 32'hFFFFFFFF);
      end else begin
        check("R2 R3 R9 word", {8'h0, out_data}, {8'h0, exp_q.pop_front()});
      end
    end
    if (rst_n && frame_done) done_cnt++;
  end

  task automatic do_start(logic [1:0] m);
    mode = m; start = 1'b1;
    cyc(1);
    start = 1'b0;
  endtask

  task automatic vs_pulse(logic par);
    odd_even = par;
    cyc(4);
    vsync_n = 1'b0;
    cyc(3);
    vsync_n = 1'b1;
    cyc(4);
  endtask

  task automatic cs_pulse();
    csync_n = 1'b0;
    cyc(2);
    csync_n = 1'b1;
    cyc(5);
  endtask

  // One line of back-to-back writes; cap says whether the field is captured
  task automatic do_line(int ln, logic par, bit cap, int nsmp);
    cs_pulse();
    for (int k = 0; k < nsmp; k++) begin
      wr_en = 1'b1;
      wr_data = seq[11:0];
      if (cap && (ln >= int'(first_line)))
        exp_q.push_back({par, ln[9:0], (k == 0), seq[11:0]});
      seq++;
      cyc(1);
    end
    wr_en = 1'b0;
    cyc(4);
  endtask

  task automatic do_field(logic par, bit cap, int nlines);
    vs_pulse(par);
    for (int ln = 1; ln <= nlines; ln++) do_line(ln, par, cap, 4);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; vsync_n = 1'b1; csync_n = 1'b1; odd_even = 1'b0;
    mode = 2'd0; first_line = 10'd1; start = 1'b0; wr_en = 1'b0;
    wr_data = '0; out_ready = 1'b1;
    cyc(3);
    check("R1 out_valid", {31'h0, out_valid}, 32'h0);
    check("R1 overflow", {31'h0, overflow}, 32'h0);
    check("R1 frame_done", {31'h0, frame_done}, 32'h0);
    rst_n = 1'b1;
    cyc(3);

    // R5: odd only; even field skipped, odd taken, done at next sync
    do_start(2'd0);
    do_field(1'b0, 1'b0, 3);
    do_field(1'b1, 1'b1, 3);
    check("R5 no done before end", done_cnt, 0);
    do_field(1'b0, 1'b0, 2);
    check("R8 done after odd field", done_cnt, 1);
    do_field(1'b1, 1'b0, 2);
    check("R8 no re-arm", done_cnt, 1);
    check("R5 all words seen", exp_q.size(), 0);

    // R6 with R12: even only, mode input changed after start
    do_start(2'd1);
    mode = 2'd0;
    do_field(1'b1, 1'b0, 2);
    do_field(1'b0, 1'b1, 3);
    do_field(1'b1, 1'b0, 2);
    check("R6 R12 done after even field", done_cnt, 2);
    check("R6 all words seen", exp_q.size(), 0);

    // R7: full frame waits for odd, takes odd then even
    do_start(2'd2);
    do_field(1'b0, 1'b0, 2);
    do_field(1'b1, 1'b1, 3);
    check("R7 no done mid frame", done_cnt, 2);
    do_field(1'b0, 1'b1, 3);
    do_field(1'b1, 1'b0, 2);
    check("R7 R8 done after frame", done_cnt, 3);
    check("R7 all words seen", exp_q.size(), 0);

    // R4: blanking lines below first_line
    first_line = 10'd3;
    do_start(2'd0);
    do_field(1'b1, 1'b1, 5);
    do_field(1'b0, 1'b0, 1);
    check("R4 done", done_cnt, 4);
    check("R4 all words seen", exp_q.size(), 0);
    first_line = 10'd1;

    // R10 R11: stall with writes piling up
    do_start(2'd0);
    vs_pulse(1'b1);
    cs_pulse();
    out_ready = 1'b0;
    for (int k = 0; k < 3; k++) begin
      wr_en = 1'b1;
      wr_data = seq[11:0];
      if (k == 0) exp_q.push_back({1'b1, 10'd1, 1'b1, seq[11:0]});
      seq++;
      cyc(1);
    end
    wr_en = 1'b0;
    cyc(2);
    check("R11 overflow set", {31'h0, overflow}, 32'h1);
    check("R10 held valid", {31'h0, out_valid}, 32'h1);
    check("R10 held word", {8'h0, out_data}, {8'h0, exp_q[0]});
    out_ready = 1'b1;
    cyc(3);
    do_line(2, 1'b1, 1'b1, 4);
    check("R11 overflow sticky", {31'h0, overflow}, 32'h1);
    vs_pulse(1'b0);
    check("R11 done", done_cnt, 5);
    check("R10 R11 all words seen", exp_q.size(), 0);
    do_start(2'd0);
    cyc(2);
    check("R11 start clears overflow", {31'h0, overflow}, 32'h0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule